// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The block gathers sixteen interrupt sources and reduces them to one request line for a host processor. Eight sources come from general-purpose input pins, each sensitive to a rising or a falling edge selected per pin. The other eight come from on-chip requesters such as timers and a serial channel, and each of these counts on its rising edge. Every source carries four state bits: enable, pending, in-service and pass. The pass bit lets a pending source take part in arbitration. Priority is fixed: source 15 is the most urgent and source 0 the least.

When the host acknowledges, the controller supplies a vector byte for the winning source in the same cycle. That source then moves from pending to in-service, and it stays there until software writes a zero to its in-service bit. While a source is in service, any source at the same level or below is held back. A more urgent source can still interrupt, so service nests. A byte-wide register port reaches all the state. The same port also drives a small general-purpose pin block with an output latch and per-pin direction.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low, and `gpio_oe` and `gpio_out` are 0x00.
- R2: Pin `gpi[k]` feeds level 0, 1, 2, 3, 6, 7, 14, 15 for k = 0..7. Edge-select bit k set to 1 picks the rising edge and 0 picks the falling edge. The other edge is ignored.
- R3: `int_req[j]` feeds level 4, 5, 8, 9, 10, 11, 12, 13 for j = 0..7, and sets that level's pending bit on a rising edge.
- R4: A source becomes pending only while its enable bit is 1. Writing 0 to an enable bit also clears that source's pending bit.
- R5: A pending source whose pass bit is 0 raises no `irq` and keeps its pending bit.
- R6: The winner is the highest-numbered source that is pending with its pass bit 1. `vector` = {vector-base bits 7:4, 4-bit level}.
- R7: In a cycle with `iack` and `irq` both high, the winner's pending bit clears and its in-service bit sets at the next clock edge. No in-service bit sets any other way.
- R8: `irq` is high only when the winner's level is above every level that is in service. A winner equal to or below an in-service level raises no `irq`.
- R9: Writing 0 to a pending or in-service bit clears it. Writing 1 to either leaves it unchanged.
- R10: Register offsets are: pin data 0x01, edge select 0x03, direction 0x05, enable 0x07/0x09, pending 0x0B/0x0D, in-service 0x0F/0x11, pass 0x13/0x15, vector base 0x17. In each pair the first register holds levels 15..8 and the second holds 7..0. The vector base reads back with bits 3:0 as zero.
- R11: `gpio_oe` equals the direction register and `gpio_out` equals the pin data latch. A read at 0x01 returns the latch for bits whose direction is 1 and the `gpi` pin for bits whose direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpi | input | 8 | General-purpose pin levels |
| int_req | input | 8 | On-chip request levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| gpio_out | output | 8 | Pin output latch |
| gpio_oe | output | 8 | Pin output enables |
| irq | output | 1 | Interrupt request to host |
| iack | input | 1 | Interrupt acknowledge from host |
| vector | output | 8 | Vector byte for the current winner |

## Verification
Some properties are checked on every cycle. Pending bits never sit outside the enable set. A raised request always has a passed pending source behind it. A request never appears with an in-service bit at or above the winner's level. An in-service bit sets only after a granted acknowledge, and then for exactly the acknowledged level.

Other behaviours need the bench's scenarios. These include the mapping of pins and on-chip requests to levels and the choice of edge. They also cover the A/B split of the register map, the vector byte seen at acknowledge, and the nested sequence in which service is ended one level at a time.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC   = 16;
    localparam int NGPI   = 8;
    localparam int NINT   = 8;
    localparam int DW     = 8;
    localparam int AW     = 5;
    localparam int IDW    = $clog2(NSRC);

    localparam logic [AW-1:0] OFS_PIN   = 5'h01;
    localparam logic [AW-1:0] OFS_EDGE  = 5'h03;
    localparam logic [AW-1:0] OFS_DIR   = 5'h05;
    localparam logic [AW-1:0] OFS_ENHI  = 5'h07;
    localparam logic [AW-1:0] OFS_ENLO  = 5'h09;
    localparam logic [AW-1:0] OFS_PDHI  = 5'h0B;
    localparam logic [AW-1:0] OFS_PDLO  = 5'h0D;
    localparam logic [AW-1:0] OFS_ISHI  = 5'h0F;
    localparam logic [AW-1:0] OFS_ISLO  = 5'h11;
    localparam logic [AW-1:0] OFS_PSHI  = 5'h13;
    localparam logic [AW-1:0] OFS_PSLO  = 5'h15;
    localparam logic [AW-1:0] OFS_VBASE = 5'h17;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] insvc;
        logic [NSRC-1:0] pass;
        logic [NGPI-1:0] edge_rise;
        logic [NGPI-1:0] dir;
        logic [NGPI-1:0] pin_latch;
        logic [NGPI-1:0] gpi_prev;
        logic [NINT-1:0] int_prev;
        logic [3:0]      vbase;
    } irq_state_t;

    // Places pin and on-chip events onto their fixed priority levels.
    function automatic logic [NSRC-1:0] place_events(input logic [NGPI-1:0] g,
                                                     input logic [NINT-1:0] i);
        return {g[7], g[6], i[7], i[6], i[5], i[4], i[3], i[2],
                g[5], g[4], i[1], i[0], g[3], g[2], g[1], g[0]};
    endfunction

endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
    parameter int N = 8
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] hit
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_comb begin
            if (rise_sel[k]) hit[k] = cur[k] & ~prev[k];
            else             hit[k] = ~cur[k] & prev[k];
        end
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N   = 16,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   cand,
    input  logic [N-1:0]   insvc,
    output logic           req,
    output logic [IDW-1:0] win_id
);
    logic           any_cand;
    logic           any_svc;
    logic [IDW-1:0] svc_id;

    always_comb begin
        any_cand = 1'b0;
        any_svc  = 1'b0;
        win_id   = '0;
        svc_id   = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
                any_cand = 1'b1;
                win_id   = IDW'(i);
            end
            if (insvc[i]) begin
                any_svc = 1'b1;
                svc_id  = IDW'(i);
            end
        end
        req = any_cand && (!any_svc || (win_id > svc_id));
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NGPI-1:0] gpi,
    input  logic [NINT-1:0] int_req,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [NGPI-1:0] gpio_out,
    output logic [NGPI-1:0] gpio_oe,
    output logic          irq,
    input  logic          iack,
    output logic [DW-1:0] vector
);
    irq_state_t st_q, st_d;

    logic [NGPI-1:0] gpi_hit;
    logic [NINT-1:0] int_hit;
    logic [NSRC-1:0] events;
    logic [NSRC-1:0] cand;
    logic [IDW-1:0]  win_id;
    logic            req;
    logic            grant;

    irq_edge #(.N(NGPI)) u_gpi_edge (
        .cur(gpi), .prev(st_q.gpi_prev), .rise_sel(st_q.edge_rise), .hit(gpi_hit)
    );

    irq_edge #(.N(NINT)) u_int_edge (
        .cur(int_req), .prev(st_q.int_prev), .rise_sel({NINT{1'b1}}), .hit(int_hit)
    );

    assign events = place_events(gpi_hit, int_hit);
    assign cand   = st_q.pend & st_q.pass;

    irq_prio #(.N(NSRC), .IDW(IDW)) u_prio (
        .cand(cand), .insvc(st_q.insvc), .req(req), .win_id(win_id)
    );

    assign irq      = req;
    assign grant    = iack & req;
    assign vector   = {st_q.vbase, win_id};
    assign gpio_out = st_q.pin_latch;
    assign gpio_oe  = st_q.dir;

    always_comb begin
        st_d          = st_q;
        st_d.gpi_prev = gpi;
        st_d.int_prev = int_req;

        if (grant) begin
            st_d.pend[win_id]  = 1'b0;
            st_d.insvc[win_id] = 1'b1;
        end

        if (reg_we) begin
            case (reg_addr)
                OFS_PIN:   st_d.pin_latch     = reg_wdata;
                OFS_EDGE:  st_d.edge_rise     = reg_wdata;
                OFS_DIR:   st_d.dir           = reg_wdata;
                OFS_ENHI:  st_d.en[15:8]      = reg_wdata;
                OFS_ENLO:  st_d.en[7:0]       = reg_wdata;
                OFS_PDHI:  st_d.pend[15:8]    = st_d.pend[15:8] & reg_wdata;
                OFS_PDLO:  st_d.pend[7:0]     = st_d.pend[7:0] & reg_wdata;
                OFS_ISHI:  st_d.insvc[15:8]   = st_d.insvc[15:8] & reg_wdata;
                OFS_ISLO:  st_d.insvc[7:0]    = st_d.insvc[7:0] & reg_wdata;
                OFS_PSHI:  st_d.pass[15:8]    = reg_wdata;
                OFS_PSLO:  st_d.pass[7:0]     = reg_wdata;
                OFS_VBASE: st_d.vbase         = reg_wdata[7:4];
                default:   ;
            endcase
        end

        // New edges win over clears in the same cycle; enable gates both.
        st_d.pend = (st_d.pend | events) & st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_PIN:   reg_rdata = (st_q.pin_latch & st_q.dir) | (gpi & ~st_q.dir);
            OFS_EDGE:  reg_rdata = st_q.edge_rise;
            OFS_DIR:   reg_rdata = st_q.dir;
            OFS_ENHI:  reg_rdata = st_q.en[15:8];
            OFS_ENLO:  reg_rdata = st_q.en[7:0];
            OFS_PDHI:  reg_rdata = st_q.pend[15:8];
            OFS_PDLO:  reg_rdata = st_q.pend[7:0];
            OFS_ISHI:  reg_rdata = st_q.insvc[15:8];
            OFS_ISLO:  reg_rdata = st_q.insvc[7:0];
            OFS_PSHI:  reg_rdata = st_q.pass[15:8];
            OFS_PSLO:  reg_rdata = st_q.pass[7:0];
            OFS_VBASE: reg_rdata = {st_q.vbase, 4'h0};
            default:   reg_rdata = '0;
        endcase
    end

    // R4: nothing stays pending without its enable
    a_r4_pend_in_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & ~st_q.en) == '0);

    // R5: a request needs a pending source whose pass bit is set
    a_r5_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((st_q.pend & st_q.pass) != '0));

    // R8: no in-service level at or above the winner while requesting
    a_r8_irq_above_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((st_q.insvc >> win_id) == '0));

    // R7: a granted acknowledge puts the acknowledged level in service
    a_r7_ack_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && irq) |=> st_q.insvc[$past(vector[3:0])]);

    // R7: no in-service bit appears without a granted acknowledge
    a_r7_no_service_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack && irq) |=> ((st_q.insvc & ~$past(st_q.insvc)) == '0));

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] gpi = '0;
    logic [7:0] int_req = '0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] gpio_out;
    logic [7:0] gpio_oe;
    logic       irq;
    logic       iack = 1'b0;
    logic [7:0] vector;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .gpi(gpi), .int_req(int_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .irq(irq), .iack(iack), .vector(vector)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        #1;
        chk(req, {7'd0, irq}, {7'd0, exp});
    endtask

    task automatic set_gpi(input logic [7:0] v);
        @(negedge clk);
        gpi = v;
    endtask

    task automatic pulse_int(input logic [7:0] v);
        @(negedge clk);
        int_req = v;
        @(negedge clk);
        int_req = '0;
    endtask

    // Driver: queues the expected vector, then acknowledges for one cycle.
    task automatic ack(input string req, input logic [7:0] exp);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
    endtask

    // Monitor: compares the vector while an acknowledge is on the bus.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (iack) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R6: vector 0x%02h with no expected entry", vector);
                end else begin
                    chk(tag_q.pop_front(), vector, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        irq_chk("R1 irq", 1'b0);
        rd_chk("R1 enable hi", 5'h07, 8'h00);
        rd_chk("R1 pending lo", 5'h0D, 8'h00);
        rd_chk("R1 in-service hi", 5'h0F, 8'h00);
        rd_chk("R1 vector base", 5'h17, 8'h00);
        chk("R1 gpio_oe", gpio_oe, 8'h00);
        chk("R1 gpio_out", gpio_out, 8'h00);

        // R10 register map and A/B split
        wr(5'h17, 8'h4A);
        rd_chk("R10 vector base low nibble", 5'h17, 8'h40);
        wr(5'h07, 8'hA5);
        wr(5'h09, 8'h3C);
        rd_chk("R10 enable hi", 5'h07, 8'hA5);
        rd_chk("R10 enable lo", 5'h09, 8'h3C);
        wr(5'h13, 8'h81);
        rd_chk("R10 pass hi", 5'h13, 8'h81);
        wr(5'h07, 8'h00);
        wr(5'h09, 8'h00);

        // R11 pin block
        wr(5'h05, 8'h0F);
        wr(5'h01, 8'h55);
        set_gpi(8'hA0);
        chk("R11 gpio_out", gpio_out, 8'h55);
        chk("R11 gpio_oe", gpio_oe, 8'h0F);
        rd_chk("R11 pin read mix", 5'h01, 8'hA5);
        set_gpi(8'h00);
        wr(5'h05, 8'h00);

        // R4 enable gating
        wr(5'h03, 8'hFF);
        set_gpi(8'h01);
        rd_chk("R4 disabled edge ignored", 5'h0D, 8'h00);
        set_gpi(8'h00);
        wr(5'h09, 8'h01);
        wr(5'h13, 8'hFF);
        wr(5'h15, 8'hFF);
        set_gpi(8'h01);
        rd_chk("R4 enabled edge pends", 5'h0D, 8'h01);
        irq_chk("R4 irq raised", 1'b1);
        wr(5'h09, 8'h00);
        rd_chk("R4 disable clears pending", 5'h0D, 8'h00);
        irq_chk("R4 irq dropped", 1'b0);
        set_gpi(8'h00);
        wr(5'h07, 8'hFF);
        wr(5'h09, 8'hFF);

        // R2 falling-edge selection on pin 1
        wr(5'h03, 8'hFD);
        set_gpi(8'h02);
        rd_chk("R2 rising ignored", 5'h0D, 8'h00);
        set_gpi(8'h00);
        rd_chk("R2 falling pends", 5'h0D, 8'h02);
        wr(5'h0D, 8'hFF);
        rd_chk("R9 write one no effect", 5'h0D, 8'h02);
        wr(5'h0D, 8'h00);
        rd_chk("R9 write zero clears", 5'h0D, 8'h00);
        wr(5'h03, 8'hFF);

        // R2 level map for pins 4, 6, 7
        set_gpi(8'hD0);
        rd_chk("R2 map hi", 5'h0B, 8'hC0);
        rd_chk("R2 map lo", 5'h0D, 8'h40);
        set_gpi(8'h00);

        // R5 blocked by pass bits, R6/R7 ack level 6
        wr(5'h13, 8'h00);
        irq_chk("R5 irq from level 6", 1'b1);
        ack("R6 vector level 6", 8'h46);
        rd_chk("R7 in-service lo", 5'h11, 8'h40);
        rd_chk("R7 pending lo cleared", 5'h0D, 8'h00);
        irq_chk("R5 no irq when pass off", 1'b0);
        rd_chk("R5 pending kept", 5'h0B, 8'hC0);

        // R6/R8 nesting
        wr(5'h13, 8'hFF);
        irq_chk("R8 higher level nests", 1'b1);
        ack("R6 vector level 15", 8'h4F);
        rd_chk("R7 in-service hi", 5'h0F, 8'h80);
        irq_chk("R8 lower level blocked", 1'b0);
        wr(5'h0F, 8'h7F);
        rd_chk("R9 end service", 5'h0F, 8'h00);
        irq_chk("R8 level 14 above 6", 1'b1);
        ack("R6 vector level 14", 8'h4E);
        rd_chk("R7 in-service hi 14", 5'h0F, 8'h40);
        wr(5'h0F, 8'h00);
        wr(5'h11, 8'h00);
        irq_chk("R8 idle", 1'b0);

        // R3 on-chip requests
        wr(5'h17, 8'hC0);
        pulse_int(8'h85);
        rd_chk("R3 pending hi", 5'h0B, 8'h21);
        rd_chk("R3 pending lo", 5'h0D, 8'h10);
        ack("R6 vector level 13", 8'hCD);
        irq_chk("R8 lower blocked", 1'b0);
        pulse_int(8'h80);
        rd_chk("R3 re-pend 13", 5'h0B, 8'h21);
        irq_chk("R8 equal blocked", 1'b0);
        wr(5'h0F, 8'h00);
        ack("R6 vector level 13 again", 8'hCD);
        wr(5'h0F, 8'h00);
        ack("R6 vector level 8", 8'hC8);
        wr(5'h0F, 8'h00);
        ack("R6 vector level 4", 8'hC4);
        rd_chk("R7 in-service lo 4", 5'h11, 8'h10);
        wr(5'h11, 8'h00);
        irq_chk("R8 all served", 1'b0);

        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R6: got %0d unchecked vectors expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule